// File: doc/BRIEF.md
# Iterative Multiply, Divide and Accumulate Coprocessor

This block sits beside a small processor and carries out one arithmetic job at a time over a fixed number of clock cycles. The processor presents two operands, an accumulator value, an operation select and a signed/unsigned mode bit, then pulses `start` for one cycle. The block latches everything on that edge and raises `busy`. When the result is ready it pulses `done` for one cycle, and the result registers then hold the new product, sum, or quotient and remainder.

A single shift-and-add multiplier that takes four multiplier bits per cycle serves both plain multiply and multiply-accumulate. A restoring divider serves both divide forms. It takes four quotient bits per cycle when the divisor is 16 bits wide and two when it is 32 bits wide. Every division has a 32-bit quotient. Signed operations run on magnitudes, and the signs are applied at the end. The accumulate can wrap or saturate. Two flags report overflow and division by zero.

Top module: `muldiv_coproc`

## Requirements
- R1: `op_sel` = 0 multiplies the low 16 bits of `opnd_a` and `opnd_b`. The 32-bit product appears on `result_lo`, and `result_hi` reads 0. `done` rises exactly 4 cycles after the clock edge that accepts `start`. When `signed_mode` is 1, every operation reads its operands as two's complement; when it is 0, as unsigned.
- R2: `op_sel` = 1 divides the 32-bit `opnd_a` by the low 16 bits of `opnd_b`, sign- or zero-extended according to the mode. The quotient goes on `result_lo` and the remainder on `result_hi`. `done` rises exactly 8 cycles after acceptance.
- R3: `op_sel` = 2 divides the 32-bit `opnd_a` by the full 32-bit `opnd_b`, with outputs as in R2. `done` rises exactly 16 cycles after acceptance.
- R4: Signed division truncates the quotient toward zero, and the remainder carries the sign of the dividend.
- R5: `op_sel` = 3 sets `result_lo` to `acc_in` plus the 16x16 product, modulo 2^32, and `result_hi` to 0. It takes 4 cycles. `ovf_flag` is set if the true sum does not fit in 32 bits of the selected signedness.
- R6: `op_sel` = 4 behaves as R5, except that an overflowing sum is clamped and `ovf_flag` is set. In signed mode the clamp is 0x7FFFFFFF for a positive overflow and 0x80000000 for a negative one. In unsigned mode it is 0xFFFFFFFF.
- R7: A zero divisor still completes in the normal cycle count. It returns 0xFFFFFFFF as the quotient and the unmodified `opnd_a` as the remainder, and it sets `divz_flag`. `divz_flag` stays set until reset.
- R8: `busy` is 1 from the accepting edge until the edge that raises `done`. A `start` pulse while `busy` is 1 is ignored. So is a `start` with `op_sel` of 5, 6 or 7.
- R9: `result_lo` and `result_hi` keep their previous values until the edge that raises `done`. `done` is high for exactly one cycle.
- R10: `ovf_flag` clears on the edge that accepts the next operation.
- R11: After reset, `busy`, `done`, both flags and both result registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| op_sel | input | 3 | Operation select (0 mul, 1 div 32/16, 2 div 32/32, 3 wrapping MAC, 4 saturating MAC) |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| opnd_a | input | 32 | Multiplicand (low 16 bits) or dividend |
| opnd_b | input | 32 | Multiplier (low 16 bits) or divisor |
| acc_in | input | 32 | Accumulator addend for MAC |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| result_lo | output | 32 | Product, sum or quotient |
| result_hi | output | 32 | Remainder, or 0 for multiply and MAC |
| ovf_flag | output | 1 | Accumulate overflowed in the last operation |
| divz_flag | output | 1 | Sticky divide-by-zero indicator |

## Verification
A wrong iteration count or a mis-decoded latency moves `done` by one or more cycles, so it shows at the ports on the very operation where it happens. A wrong partial remainder, a wrong quotient shift or a wrong sign fix-up stays hidden inside the block until the final edge. It then shows as a wrong `result_lo` or `result_hi` in the single cycle that `done` is high. A stale overflow or divide-by-zero state shows in the flags either on the accepting edge of the next job or at its `done`. Because of this, the bench samples every output in the cycle the requirements fix for it, rather than waiting for the outputs to settle.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int DW = 32;
    localparam int HW = 16;

    localparam int LAT_MUL  = 4;
    localparam int LAT_DIVH = 8;
    localparam int LAT_DIVW = 16;

    localparam int MUL_DIGIT = HW / LAT_MUL;
    localparam int DIVH_BITS = DW / LAT_DIVH;
    localparam int DIVW_BITS = DW / LAT_DIVW;
    localparam int CW        = $clog2(LAT_DIVW + 1);

    typedef enum logic [2:0] {
        OP_MUL  = 3'd0,
        OP_DIVH = 3'd1,
        OP_DIVW = 3'd2,
        OP_MACW = 3'd3,
        OP_MACS = 3'd4
    } op_e;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        op_e           op;
        logic          sgn;
        logic          neg_q;
        logic          neg_r;
        logic          divz;
        logic [DW:0]   work;
        logic [DW-1:0] aux;
        logic [DW-1:0] sh;
        logic [DW-1:0] keep;
        logic [DW-1:0] res_lo;
        logic [DW-1:0] res_hi;
        logic          ovf;
        logic          dzf;
    } mdu_state_t;

    function automatic logic [CW-1:0] lat_of(input op_e op);
        case (op)
            OP_DIVH: return CW'(LAT_DIVH);
            OP_DIVW: return CW'(LAT_DIVW);
            default: return CW'(LAT_MUL);
        endcase
    endfunction

    function automatic logic [HW-1:0] mag_h(input logic [HW-1:0] v, input logic s);
        return (s && v[HW-1]) ? (~v + 1'b1) : v;
    endfunction

    function automatic logic [DW-1:0] mag_w(input logic [DW-1:0] v, input logic s);
        return (s && v[DW-1]) ? (~v + 1'b1) : v;
    endfunction

    function automatic logic [DW-1:0] ext_h(input logic [HW-1:0] v, input logic s);
        return s ? {{(DW-HW){v[HW-1]}}, v} : {{(DW-HW){1'b0}}, v};
    endfunction

endpackage

// File: rtl/mdu_mul_step.sv
module mdu_mul_step #(
    parameter int W   = 32,
    parameter int NIB = 4
) (
    input  logic [W-1:0]   acc_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [NIB-1:0] digit_i,
    output logic [W-1:0]   acc_o
);
    always_comb begin
        acc_o = acc_i;
        for (int k = 0; k < NIB; k++) begin
            if (digit_i[k]) begin
                acc_o = acc_o + (mcand_i << k);
            end
        end
    end
endmodule

// File: rtl/mdu_div_step.sv
module mdu_div_step #(
    parameter int W    = 32,
    parameter int BITS = 2
) (
    input  logic [W:0]   rem_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dsr_i,
    output logic [W:0]   rem_o,
    output logic [W-1:0] dvd_o
);
    always_comb begin
        rem_o = rem_i;
        dvd_o = dvd_i;
        for (int k = 0; k < BITS; k++) begin
            rem_o = {rem_o[W-1:0], dvd_o[W-1]};
            dvd_o = {dvd_o[W-2:0], 1'b0};
            if (rem_o >= {1'b0, dsr_i}) begin
                rem_o    = rem_o - {1'b0, dsr_i};
                dvd_o[0] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdu_acc_sat.sv
module mdu_acc_sat #(
    parameter int W = 32
) (
    input  logic         sgn_i,
    input  logic         sat_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] prod_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    logic [W:0] sum_ext;
    logic       pos_ovf;
    logic       neg_ovf;

    always_comb begin
        if (sgn_i) begin
            sum_ext = {acc_i[W-1], acc_i} + {prod_i[W-1], prod_i};
            pos_ovf = !sum_ext[W] && sum_ext[W-1];
            neg_ovf = sum_ext[W] && !sum_ext[W-1];
        end else begin
            sum_ext = {1'b0, acc_i} + {1'b0, prod_i};
            pos_ovf = sum_ext[W];
            neg_ovf = 1'b0;
        end
        ovf_o = pos_ovf || neg_ovf;
        sum_o = sum_ext[W-1:0];
        if (sat_i && ovf_o) begin
            if (!sgn_i)      sum_o = '1;
            else if (pos_ovf) sum_o = {1'b0, {(W-1){1'b1}}};
            else             sum_o = {1'b1, {(W-1){1'b0}}};
        end
    end
endmodule

// File: rtl/muldiv_coproc.sv
module muldiv_coproc
    import mdu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [2:0]  op_sel,
    input  logic        signed_mode,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [31:0] acc_in,
    output logic        busy,
    output logic        done,
    output logic [31:0] result_lo,
    output logic [31:0] result_hi,
    output logic        ovf_flag,
    output logic        divz_flag
);
    mdu_state_t s_q, s_d;

    logic          accept;
    op_e           op_in;
    logic [HW-1:0] am_h, bm_h;
    logic [DW-1:0] dsr_in;
    logic [DW-1:0] mul_acc;
    logic [DW-1:0] prod_fin;
    logic [DW:0]   remh, remw, rem_sel;
    logic [DW-1:0] dvdh, dvdw, dvd_sel;
    logic [DW-1:0] mac_sum;
    logic          mac_ovf;

    assign op_in  = op_e'(op_sel);
    assign accept = start && !s_q.busy && (op_sel <= 3'd4);

    mdu_mul_step #(.W(DW), .NIB(MUL_DIGIT)) u_mul (
        .acc_i   (s_q.work[DW-1:0]),
        .mcand_i (s_q.aux),
        .digit_i (s_q.sh[MUL_DIGIT-1:0]),
        .acc_o   (mul_acc)
    );

    assign prod_fin = s_q.neg_q ? (~mul_acc + 1'b1) : mul_acc;

    mdu_div_step #(.W(DW), .BITS(DIVH_BITS)) u_divh (
        .rem_i (s_q.work),
        .dvd_i (s_q.aux),
        .dsr_i (s_q.sh),
        .rem_o (remh),
        .dvd_o (dvdh)
    );

    mdu_div_step #(.W(DW), .BITS(DIVW_BITS)) u_divw (
        .rem_i (s_q.work),
        .dvd_i (s_q.aux),
        .dsr_i (s_q.sh),
        .rem_o (remw),
        .dvd_o (dvdw)
    );

    assign rem_sel = (s_q.op == OP_DIVH) ? remh : remw;
    assign dvd_sel = (s_q.op == OP_DIVH) ? dvdh : dvdw;

    mdu_acc_sat #(.W(DW)) u_sat (
        .sgn_i  (s_q.sgn),
        .sat_i  (s_q.op == OP_MACS),
        .acc_i  (s_q.keep),
        .prod_i (prod_fin),
        .sum_o  (mac_sum),
        .ovf_o  (mac_ovf)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        am_h     = mag_h(opnd_a[HW-1:0], signed_mode);
        bm_h     = mag_h(opnd_b[HW-1:0], signed_mode);
        dsr_in   = (op_in == OP_DIVH) ? ext_h(opnd_b[HW-1:0], signed_mode) : opnd_b;

        if (accept) begin
            s_d.busy = 1'b1;
            s_d.cnt  = lat_of(op_in);
            s_d.op   = op_in;
            s_d.sgn  = signed_mode;
            s_d.ovf  = 1'b0;
            s_d.work = '0;
            if (op_in == OP_DIVH || op_in == OP_DIVW) begin
                s_d.aux   = mag_w(opnd_a, signed_mode);
                s_d.sh    = mag_w(dsr_in, signed_mode);
                s_d.neg_q = signed_mode && (opnd_a[DW-1] ^ dsr_in[DW-1]);
                s_d.neg_r = signed_mode && opnd_a[DW-1];
                s_d.divz  = (dsr_in == '0);
                s_d.keep  = opnd_a;
            end else begin
                s_d.aux   = {{(DW-HW){1'b0}}, am_h};
                s_d.sh    = {{(DW-HW){1'b0}}, bm_h};
                s_d.neg_q = signed_mode && (opnd_a[HW-1] ^ opnd_b[HW-1]);
                s_d.neg_r = 1'b0;
                s_d.divz  = 1'b0;
                s_d.keep  = acc_in;
            end
        end else if (s_q.busy) begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.op == OP_DIVH || s_q.op == OP_DIVW) begin
                s_d.work = rem_sel;
                s_d.aux  = dvd_sel;
            end else begin
                s_d.work = {1'b0, mul_acc};
                s_d.aux  = s_q.aux << MUL_DIGIT;
                s_d.sh   = s_q.sh >> MUL_DIGIT;
            end
            if (s_q.cnt == CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                case (s_q.op)
                    OP_MUL: begin
                        s_d.res_lo = prod_fin;
                        s_d.res_hi = '0;
                    end
                    OP_MACW, OP_MACS: begin
                        s_d.res_lo = mac_sum;
                        s_d.res_hi = '0;
                        s_d.ovf    = mac_ovf;
                    end
                    default: begin
                        if (s_q.divz) begin
                            s_d.res_lo = '1;
                            s_d.res_hi = s_q.keep;
                            s_d.dzf    = 1'b1;
                        end else begin
                            s_d.res_lo = s_q.neg_q ? (~dvd_sel + 1'b1) : dvd_sel;
                            s_d.res_hi = s_q.neg_r ? (~rem_sel[DW-1:0] + 1'b1)
                                                   : rem_sel[DW-1:0];
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign done      = s_q.done;
    assign result_lo = s_q.res_lo;
    assign result_hi = s_q.res_hi;
    assign ovf_flag  = s_q.ovf;
    assign divz_flag = s_q.dzf;

    // Latency checker: counts edges since acceptance, independent of s_q.cnt.
    logic [CW-1:0] chk_cnt;
    logic [CW-1:0] chk_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_cnt <= '0;
            chk_lat <= '0;
        end else if (accept) begin
            chk_cnt <= '0;
            chk_lat <= (op_in == OP_DIVH) ? CW'(8) : (op_in == OP_DIVW) ? CW'(16) : CW'(4);
        end else if (busy) begin
            chk_cnt <= chk_cnt + 1'b1;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chk_cnt == chk_lat)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(result_lo) && $stable(result_hi))); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (chk_lat == $past(chk_lat))); // R8
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !ovf_flag); // R10
    AST_DZ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(divz_flag) |-> divz_flag); // R7
    AST_DZ_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.divz) |-> ((result_lo == '1) && divz_flag)); // R7
    AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf_flag && s_q.op == OP_MACS) |->
        (s_q.sgn ? (result_lo == 32'h7FFF_FFFF || result_lo == 32'h8000_0000)
                 : (result_lo == 32'hFFFF_FFFF))); // R6

endmodule

// File: tb/sim_muldiv_coproc.sv
module sim_muldiv_coproc;

    logic        clk, rst_n, start, signed_mode;
    logic [2:0]  op_sel;
    logic [31:0] opnd_a, opnd_b, acc_in;
    logic        busy, done, ovf_flag, divz_flag;
    logic [31:0] result_lo, result_hi;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;

    muldiv_coproc u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .signed_mode(signed_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .acc_in(acc_in), .busy(busy), .done(done), .result_lo(result_lo),
        .result_hi(result_hi), .ovf_flag(ovf_flag), .divz_flag(divz_flag)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Stimulus: {op[2:0], sgn, a[31:0], b[31:0], acc[31:0]}
    localparam int NV = 15;
    localparam logic [99:0] VEC [NV] = '{
        {3'd0, 1'b0, 32'h0000FFFF, 32'h0000FFFF, 32'h0},
        {3'd0, 1'b1, 32'h0000FFFF, 32'h00000003, 32'h0},
        {3'd0, 1'b1, 32'h00008000, 32'h00008000, 32'h0},
        {3'd1, 1'b0, 32'h12345678, 32'h00001234, 32'h0},
        {3'd1, 1'b1, 32'hFFFFFF9C, 32'h00000007, 32'h0},
        {3'd1, 1'b1, 32'h00000064, 32'h0000FFF9, 32'h0},
        {3'd2, 1'b0, 32'hFFFFFFFF, 32'h00010001, 32'h0},
        {3'd2, 1'b1, 32'h80000001, 32'h7FFFFFFF, 32'h0},
        {3'd2, 1'b0, 32'h00000005, 32'h00000009, 32'h0},
        {3'd3, 1'b0, 32'h00000002, 32'h00000001, 32'hFFFFFFFF},
        {3'd3, 1'b1, 32'h0000FFFE, 32'h00000005, 32'h00000010},
        {3'd4, 1'b1, 32'h00007FFF, 32'h00007FFF, 32'h7FFFFFF0},
        {3'd4, 1'b1, 32'h00007FFF, 32'h00008000, 32'h80000000},
        {3'd4, 1'b0, 32'h0000FFFF, 32'h0000FFFF, 32'hFFFF0000},
        {3'd4, 1'b1, 32'h00000002, 32'h00000003, 32'h00000100}
    };

    // Reference model built from R1..R7: returns {ovf, lo, hi}
    function automatic logic [64:0] model(input logic [2:0] op, input logic sg,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] acc);
        logic [31:0] p, q, r, d;
        logic signed [31:0] ps, qs, rs;
        logic signed [33:0] ss;
        logic [33:0] su;
        logic ov;
        ov = 1'b0;
        if (sg) begin
            ps = $signed(a[15:0]) * $signed(b[15:0]);
            p  = ps;
        end else begin
            p = a[15:0] * b[15:0];
        end
        if (op == 3'd0) return {1'b0, p, 32'h0};
        if (op == 3'd3 || op == 3'd4) begin
            if (sg) begin
                ss = $signed(acc) + $signed(p);
                ov = (ss > 34'sh0_7FFF_FFFF) || (ss < -34'sh0_8000_0000);
                q  = ss[31:0];
                if (ov && op == 3'd4) q = ss[33] ? 32'h80000000 : 32'h7FFFFFFF;
            end else begin
                su = {2'b0, acc} + {2'b0, p};
                ov = su[32];
                q  = su[31:0];
                if (ov && op == 3'd4) q = 32'hFFFFFFFF;
            end
            return {ov, q, 32'h0};
        end
        d = (op == 3'd1) ? (sg ? {{16{b[15]}}, b[15:0]} : {16'h0, b[15:0]}) : b;
        if (d == 0) return {1'b0, 32'hFFFFFFFF, a};
        if (sg) begin
            qs = $signed(a) / $signed(d);
            rs = $signed(a) % $signed(d);
            return {1'b0, qs, rs};
        end
        q = a / d;
        r = a % d;
        return {1'b0, q, r};
    endfunction

    function automatic int lat_exp(input logic [2:0] op);
        return (op == 3'd1) ? 8 : (op == 3'd2) ? 16 : 4;
    endfunction

    // Issues one operation; optionally pokes a second start while busy (R8).
    task automatic run_op(input logic [2:0] op, input logic sg, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] acc,
                          input bit poke, output int lat);
        logic [31:0] old_lo, old_hi;
        old_lo = result_lo;
        old_hi = result_hi;
        @(negedge clk);
        op_sel = op; signed_mode = sg; opnd_a = a; opnd_b = b; acc_in = acc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        check("R8 busy after accept", {31'h0, busy}, 32'h1);
        check("R10 ovf cleared at accept", {31'h0, ovf_flag}, 32'h0);
        check("R9 result_lo held", result_lo, old_lo);
        check("R9 result_hi held", result_hi, old_hi);
        while (lat < 40) begin
            if (poke && lat == 1) begin
                op_sel = 3'd2; opnd_a = 32'h1; opnd_b = 32'h1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            lat++;
            if (done) break;
        end
        start = 1'b0;
        check("R8 busy low at done", {31'h0, busy}, 32'h0);
    endtask

    initial begin
        int lat;
        logic [64:0] e;
        string tag;
        rst_n = 1'b0; start = 1'b0; op_sel = 3'd0; signed_mode = 1'b0;
        opnd_a = '0; opnd_b = '0; acc_in = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 busy", {31'h0, busy}, 32'h0);
        check("R11 done", {31'h0, done}, 32'h0);
        check("R11 result_lo", result_lo, 32'h0);
        check("R11 result_hi", result_hi, 32'h0);
        check("R11 flags", {30'h0, ovf_flag, divz_flag}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [2:0] vop;
            vop = VEC[i][99:97];
            tag = (vop == 3'd0) ? "R1" : (vop == 3'd1) ? "R2/R4" : (vop == 3'd2) ? "R3/R4"
                : (vop == 3'd3) ? "R5" : "R6";
            e = model(vop, VEC[i][96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
            run_op(vop, VEC[i][96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], 1'b0, lat);
            check({tag, " latency"}, lat, lat_exp(vop));
            check({tag, " result_lo"}, result_lo, e[63:32]);
            check({tag, " result_hi"}, result_hi, e[31:0]);
            check({tag, " ovf"}, {31'h0, ovf_flag}, {31'h0, e[64]});
            check("R7 no divz yet", {31'h0, divz_flag}, 32'h0);
        end

        // R4 explicit signs: -100 / 7 -> -14 rem -2
        run_op(3'd1, 1'b1, 32'hFFFFFF9C, 32'h00000007, 32'h0, 1'b0, lat);
        check("R4 quotient toward zero", result_lo, 32'hFFFFFFF2);
        check("R4 remainder sign", result_hi, 32'hFFFFFFFE);

        // R6 explicit clamps
        run_op(3'd4, 1'b1, 32'h00007FFF, 32'h00007FFF, 32'h7FFFFFF0, 1'b0, lat);
        check("R6 positive clamp", result_lo, 32'h7FFFFFFF);
        check("R6 ovf set", {31'h0, ovf_flag}, 32'h1);
        // R10: next operation clears ovf (checked at accept in run_op)
        run_op(3'd0, 1'b0, 32'h3, 32'h5, 32'h0, 1'b0, lat);
        check("R10 ovf stays clear", {31'h0, ovf_flag}, 32'h0);
        check("R1 small product", result_lo, 32'hF);

        // R8 start ignored while busy: a multiply must keep its own latency/result
        run_op(3'd0, 1'b0, 32'h00000007, 32'h00000006, 32'h0, 1'b1, lat);
        check("R8 latency unaffected by poke", lat, 4);
        check("R8 result unaffected by poke", result_lo, 32'd42);
        repeat (2) @(negedge clk);
        check("R8 poke not queued", {31'h0, busy}, 32'h0);

        // R8 undefined op codes ignored
        @(negedge clk);
        op_sel = 3'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 op 5 not accepted", {31'h0, busy}, 32'h0);
        repeat (6) @(negedge clk);
        check("R8 op 5 no done", {31'h0, done}, 32'h0);
        check("R8 op 5 results kept", result_lo, 32'd42);

        // R7 divide by zero, both widths
        run_op(3'd1, 1'b1, 32'h87654321, 32'hFFFF0000, 32'h0, 1'b0, lat);
        check("R7 latency 32/16", lat, 8);
        check("R7 quotient", result_lo, 32'hFFFFFFFF);
        check("R7 remainder", result_hi, 32'h87654321);
        check("R7 flag set", {31'h0, divz_flag}, 32'h1);
        run_op(3'd2, 1'b0, 32'h00ABCDEF, 32'h0, 32'h0, 1'b0, lat);
        check("R7 latency 32/32", lat, 16);
        check("R7 remainder 32/32", result_hi, 32'h00ABCDEF);
        run_op(3'd2, 1'b0, 32'd100, 32'd7, 32'h0, 1'b0, lat);
        check("R3 after divz quotient", result_lo, 32'd14);
        check("R7 flag sticky", {31'h0, divz_flag}, 32'h1);

        // R9 done lasts one cycle
        @(negedge clk);
        check("R9 done single cycle", {31'h0, done}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule